// File: doc/BRIEF.md
# Packet Receive FIFO with Register Read Port

This block takes 32-bit words from an AXI4-Stream sink port (data, valid, ready, last) and stores them. It keeps one byte-length entry per finished packet in a separate queue. Software reaches the stored traffic through a small register read port. An occupancy register counts the packets that are ready. A length register hands out the byte size of the oldest packet and opens that packet for reading. A data register pops one word of the open packet on each read.

Software must read in a fixed order: occupancy, then length, then exactly the announced number of data words. The block checks this order. It reports misuse as single-cycle pulses on an event vector, whose bit positions are decoded by a separate interrupt controller. A completed inbound packet and a finished keyed flush also pulse event bits. Writing the key word to the flush register empties everything at once.

Both queue depths are parameters and must be powers of two. A single packet must not be longer than the data depth.

Top module: `pktrx_fifo`

## Requirements
- R1: A stream word is taken when s_valid and s_ready are both high. s_ready is low whenever the data store holds DEPTH words or the length queue holds LQ_DEPTH entries.
- R2: A read of address 0x1C returns the number of complete packets whose length has not yet been read. It is nonzero whenever at least one such packet exists.
- R3: A read of address 0x24 returns the byte length of the oldest complete packet, which is four times its word count and so always a multiple of four, and opens that packet. With no complete packet it returns 0.
- R4: Each read of address 0x20 while words of the open packet remain returns the next word in arrival order and removes it.
- R5: Accepting a word with s_last high raises evt bit 26 for one cycle, in the cycle after the acceptance.
- R6: A length read while words of the open packet are still unread raises evt bit 26+5=31 (under-read). Those leftover words are discarded, so the same read opens the next packet cleanly.
- R7: A data read with no words left in the open packet while the store is not empty raises evt bit 30 (over-read). It returns 0 and removes nothing.
- R8: A data read while the data store is empty raises evt bit 29 (underrun) and returns 0.
- R9: Writing exactly 0x000000A5 to address 0x18 empties both queues, drops any partial packet and closes the open packet. It raises evt bit 23 in the next cycle, and a word offered in the same cycle is dropped.
- R10: Writing any other value to 0x18, or writing any other address, changes nothing.
- R11: Read data appears on reg_rdata in the cycle after reg_rd_en and holds until the next read. evt bits other than 31, 30, 29, 26 and 23 are always 0, and every event lasts one cycle.
- R12: After reset s_ready is high, evt is 0 and the occupancy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_data | input | 32 | Stream word |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Block can take a word |
| s_last | input | 1 | Word closes its packet |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the strobe |
| evt | output | 32 | One-cycle event pulses for the interrupt controller |

## Verification
The stream side and the register side run independently, so a packet can complete in the same cycle that software reads occupancy or length. In that cycle the read must report the state from before the new packet, and bit 26 must still pulse. A flush can also land in the middle of an inbound packet; it must drop the word taken in that cycle, and the rest of that packet then forms a shorter new packet. The bench provokes both cases by running the stream writer and the register reader as parallel processes. A behavioural queue model in the bench judges the result on every clock: it checks s_ready, the event vector and each returned read value.

// File: rtl/pktrx_pkg.sv
package pktrx_pkg;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] A_FLUSH = 6'h18;
  localparam logic [REG_AW-1:0] A_OCC   = 6'h1C;
  localparam logic [REG_AW-1:0] A_DATA  = 6'h20;
  localparam logic [REG_AW-1:0] A_LEN   = 6'h24;

  localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;

  localparam int unsigned EV_UNDER  = 31;
  localparam int unsigned EV_OVER   = 30;
  localparam int unsigned EV_EMPTY  = 29;
  localparam int unsigned EV_RXDONE = 26;
  localparam int unsigned EV_FLUSH  = 23;

  localparam logic [31:0] EV_MASK = (32'd1 << EV_UNDER) | (32'd1 << EV_OVER) |
                                    (32'd1 << EV_EMPTY) | (32'd1 << EV_RXDONE) |
                                    (32'd1 << EV_FLUSH);
endpackage

// File: rtl/pktrx_store.sv
// Circular word store with push, pop, bulk discard and flush.
module pktrx_store #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic [CW-1:0] drop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_q] <= push_data;
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + 1'b1;
      rd_d  = rd_q + AW'(pop) + AW'(drop);
      cnt_d = cnt_q + CW'(push) - CW'(pop) - drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/pktrx_rd_seq.sv
// Register decode, read-order tracking and event generation.
module pktrx_rd_seq
  import pktrx_pkg::*;
#(
  parameter int DCW = 6,
  parameter int LCW = 4,
  localparam int LW = DCW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              rx_done,
  input  logic [LCW-1:0]    lq_cnt,
  input  logic [LW-1:0]     lq_head,
  input  logic [DCW-1:0]    dq_cnt,
  input  logic [31:0]       dq_head,
  output logic              lq_pop,
  output logic              dq_pop,
  output logic [DCW-1:0]    dq_drop,
  output logic              flush,
  output logic [31:0]       rdata,
  output logic [31:0]       evt
);
  logic [DCW-1:0] rem_q, rem_d;
  logic [31:0]    rdata_q, rdata_d;
  logic [31:0]    evt_q, evt_d;

  assign flush = wr_en && (addr == A_FLUSH) && (wdata == FLUSH_KEY);

  always_comb begin
    rem_d   = rem_q;
    rdata_d = '0;
    evt_d   = '0;
    lq_pop  = 1'b0;
    dq_pop  = 1'b0;
    dq_drop = '0;
    evt_d[EV_RXDONE] = rx_done;
    if (flush) begin
      rem_d = '0;
      evt_d[EV_FLUSH] = 1'b1;
    end else if (rd_en) begin
      unique case (addr)
        A_OCC: rdata_d = 32'(lq_cnt);
        A_LEN: begin
          if (rem_q != '0) begin
            evt_d[EV_UNDER] = 1'b1;
            dq_drop = rem_q;
          end
          if (lq_cnt != '0) begin
            lq_pop  = 1'b1;
            rdata_d = 32'(lq_head);
            rem_d   = lq_head[LW-1:2];
          end else begin
            rem_d = '0;
          end
        end
        A_DATA: begin
          if (rem_q != '0) begin
            dq_pop  = 1'b1;
            rdata_d = dq_head;
            rem_d   = rem_q - 1'b1;
          end else if (dq_cnt == '0) begin
            evt_d[EV_EMPTY] = 1'b1;
          end else begin
            evt_d[EV_OVER] = 1'b1;
          end
        end
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      rdata_q <= '0;
      evt_q   <= '0;
    end else begin
      rem_q <= rem_d;
      evt_q <= evt_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign evt   = evt_q;
endmodule

// File: rtl/pktrx_fifo.sv
module pktrx_fifo
  import pktrx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int LQ_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       s_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_last,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       evt
);
  localparam int DCW = $clog2(DEPTH + 1);
  localparam int LCW = $clog2(LQ_DEPTH + 1);
  localparam int LW  = DCW + 2;

  logic [DCW-1:0] dq_cnt, dq_drop, part_q, part_d, part_inc;
  logic [LCW-1:0] lq_cnt;
  logic [LW-1:0]  lq_head, lq_push_len;
  logic [31:0]    dq_head;
  logic           lq_pop, dq_pop, flush, accept, rx_done;

  assign s_ready     = (dq_cnt < DCW'(DEPTH)) && (lq_cnt < LCW'(LQ_DEPTH));
  assign accept      = s_valid && s_ready;
  assign rx_done     = accept && s_last && !flush;
  assign part_inc    = part_q + 1'b1;
  assign lq_push_len = {part_inc, 2'b00};

  always_comb begin
    part_d = part_q;
    if (flush)       part_d = '0;
    else if (accept) part_d = s_last ? '0 : part_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) part_q <= '0;
    else        part_q <= part_d;
  end

  pktrx_store #(.W(32), .DEPTH(DEPTH)) data_q_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(accept), .push_data(s_data),
    .pop(dq_pop), .drop(dq_drop), .head(dq_head), .count(dq_cnt)
  );

  pktrx_store #(.W(LW), .DEPTH(LQ_DEPTH)) len_q_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_done), .push_data(lq_push_len),
    .pop(lq_pop), .drop('0), .head(lq_head), .count(lq_cnt)
  );

  pktrx_rd_seq #(.DCW(DCW), .LCW(LCW)) seq_i (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd_en), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rx_done(rx_done), .lq_cnt(lq_cnt), .lq_head(lq_head),
    .dq_cnt(dq_cnt), .dq_head(dq_head), .lq_pop(lq_pop), .dq_pop(dq_pop),
    .dq_drop(dq_drop), .flush(flush), .rdata(reg_rdata), .evt(evt)
  );
endmodule

// File: rtl/pktrx_fifo_chk.sv
module pktrx_fifo_chk
  import pktrx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DCW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic              reg_rd_en,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       evt,
  input logic [DCW-1:0]    dq_cnt
);
  logic key_wr;
  assign key_wr = reg_wr_en && (reg_addr == A_FLUSH) && (reg_wdata == FLUSH_KEY);

  assert_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_cnt == DCW'(DEPTH)) |-> !s_ready);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_cnt <= DCW'(DEPTH));

  assert_len_mult4_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == A_LEN) |=> (reg_rdata[1:0] == 2'b00));

  assert_rx_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last && !key_wr) |=> evt[EV_RXDONE]);

  assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == A_DATA && dq_cnt == '0 && !key_wr) |=>
      (evt[EV_EMPTY] && reg_rdata == '0));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (evt[EV_FLUSH] && dq_cnt == '0));

  assert_evt_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~EV_MASK) == '0);
endmodule

bind pktrx_fifo pktrx_fifo_chk #(.DEPTH(DEPTH), .DCW(DCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .dq_cnt(dq_cnt)
);

// File: tb/pktrx_fifo_tb_top.sv
module pktrx_fifo_tb_top;
  localparam int DEPTH = 32;
  localparam int LQ    = 8;
  localparam logic [5:0] AF = 6'h18, AO = 6'h1C, AD = 6'h20, AL = 6'h24;

  logic clk, rst_n;
  logic [31:0] s_data, reg_wdata, reg_rdata, evt;
  logic s_valid, s_ready, s_last, reg_rd_en, reg_wr_en;
  logic [5:0] reg_addr;

  int n_chk = 0, n_err = 0;
  bit chk_en = 0, done = 0;

  pktrx_fifo #(.DEPTH(DEPTH), .LQ_DEPTH(LQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_last(s_last), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_dq[$];
  int          m_lq[$];
  int          m_part, m_rem;
  logic [31:0] m_exp_rd, m_exp_ev, m_tmp;
  bit          m_last_rd;
  logic [5:0]  m_last_addr;

  function automatic bit m_ready();
    return (m_dq.size() < DEPTH) && (m_lq.size() < LQ);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dq.delete(); m_lq.delete();
      m_part = 0; m_rem = 0; m_exp_ev = 0; m_last_rd = 0;
    end else begin
      bit acc;
      acc = s_valid && m_ready();
      m_exp_ev = 0;
      if (reg_wr_en && reg_addr == AF && reg_wdata == 32'hA5) begin
        m_dq.delete(); m_lq.delete();
        m_part = 0; m_rem = 0;
        m_exp_ev[23] = 1;
        if (reg_rd_en) m_exp_rd = 0;
      end else begin
        if (reg_rd_en) begin
          m_exp_rd = 0;
          if (reg_addr == AO) m_exp_rd = m_lq.size();
          else if (reg_addr == AL) begin
            if (m_rem > 0) begin
              m_exp_ev[31] = 1;
              for (int k = 0; k < m_rem; k++) m_tmp = m_dq.pop_front();
            end
            if (m_lq.size() > 0) begin
              m_exp_rd = m_lq.pop_front();
              m_rem = m_exp_rd / 4;
            end else m_rem = 0;
          end else if (reg_addr == AD) begin
            if (m_rem > 0) begin
              m_exp_rd = m_dq.pop_front();
              m_rem--;
            end else if (m_dq.size() == 0) m_exp_ev[29] = 1;
            else m_exp_ev[30] = 1;
          end
        end
        if (acc) begin
          m_dq.push_back(s_data);
          m_part++;
          if (s_last) begin
            m_lq.push_back(m_part * 4);
            m_part = 0;
            m_exp_ev[26] = 1;
          end
        end
      end
      m_last_rd = reg_rd_en;
      m_last_addr = reg_addr;
    end
  end

  function automatic string ev_tag(input logic [31:0] d);
    if (d[31]) return "R6";
    if (d[30]) return "R7";
    if (d[29]) return "R8";
    if (d[26]) return "R5";
    if (d[23]) return "R9";
    return "R11";
  endfunction

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk(s_ready == m_ready(), "R1 model s_ready", 32'(s_ready), 32'(m_ready()));
      chk(evt == m_exp_ev, ev_tag(evt ^ m_exp_ev), evt, m_exp_ev);
      if (m_last_rd)
        chk(reg_rdata == m_exp_rd,
            (m_last_addr == AO) ? "R2 model" : (m_last_addr == AL) ? "R3 model" : "R4 model",
            reg_rdata, m_exp_rd);
    end
  end

  // Stimulus tasks: enter and leave at a falling edge
  task automatic send_pkt(input int n, input logic [31:0] base, input bit chk_done);
    int i = 0;
    while (i < n) begin
      bit acc;
      s_data = base + i; s_last = (i == n - 1); s_valid = 1;
      acc = s_ready;
      @(negedge clk);
      if (acc) i++;
    end
    s_valid = 0; s_last = 0;
    if (chk_done) chk(evt[26], "R5 rx-complete pulse", evt, 32'h0400_0000);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v, output logic [31:0] e);
    reg_addr = a; reg_rd_en = 1;
    @(negedge clk);
    reg_rd_en = 0;
    v = reg_rdata; e = evt;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, output logic [31:0] e);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1;
    @(negedge clk);
    reg_wr_en = 0;
    e = evt;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e, ln;
    rst_n = 0; s_valid = 0; s_last = 0; s_data = 0;
    reg_rd_en = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_en = 1;
    chk(s_ready == 1'b1, "R12 ready after reset", 32'(s_ready), 1);
    chk(evt == 0, "R12 evt after reset", evt, 0);
    rd(AO, v, e); chk(v == 0, "R12 occupancy after reset", v, 0);

    // main path
    send_pkt(3, 32'h100, 1); send_pkt(1, 32'h200, 1); send_pkt(5, 32'h300, 1);
    rd(AO, v, e); chk(v == 3, "R2 occupancy three packets", v, 3);
    rd(AL, v, e); chk(v == 12, "R3 length first packet", v, 12);
    for (int k = 0; k < 3; k++) begin
      rd(AD, v, e); chk(v == 32'h100 + k, "R4 data order", v, 32'h100 + k);
    end
    rd(AO, v, e); chk(v == 2, "R2 occupancy after one read", v, 2);
    rd(AL, v, e); chk(v == 4, "R3 length single word", v, 4);
    rd(AD, v, e); chk(v == 32'h200, "R4 single word", v, 32'h200);

    // under-read
    send_pkt(2, 32'h400, 1);
    rd(AL, v, e); chk(v == 20, "R3 length five words", v, 20);
    rd(AD, v, e); rd(AD, v, e);
    rd(AL, v, e);
    chk(e[31], "R6 under-read event", e, 32'h8000_0000);
    chk(v == 8, "R6 next packet length after discard", v, 8);
    rd(AD, v, e); chk(v == 32'h400, "R6 first word after discard", v, 32'h400);
    rd(AD, v, e); chk(v == 32'h401, "R6 second word after discard", v, 32'h401);

    // over-read, underrun, pulse width
    send_pkt(1, 32'h500, 1);
    rd(AD, v, e);
    chk(e[30], "R7 over-read event", e, 32'h4000_0000);
    chk(v == 0, "R7 over-read data", v, 0);
    rd(AL, v, e); rd(AD, v, e); chk(v == 32'h500, "R7 nothing removed", v, 32'h500);
    rd(AD, v, e);
    chk(e[29], "R8 underrun event", e, 32'h2000_0000);
    chk(v == 0, "R8 underrun data", v, 0);
    @(negedge clk);
    chk(evt == 0, "R11 event lasts one cycle", evt, 0);

    // keyed flush
    send_pkt(2, 32'h600, 1);
    wr(AF, 32'h5A, e);
    wr(AO, 32'hA5, e);
    wr(AF, 32'h1A5, e);
    rd(AO, v, e); chk(v == 1, "R10 wrong key ignored", v, 1);
    wr(AF, 32'hA5, e);
    chk(e[23], "R9 flush event", e, 32'h0080_0000);
    rd(AO, v, e); chk(v == 0, "R9 occupancy after flush", v, 0);
    rd(AD, v, e); chk(e[29], "R9 storage empty after flush", e, 32'h2000_0000);

    // length queue full
    fork
      for (int p = 0; p < LQ + 1; p++) send_pkt(1, 32'h700 + p, 1);
      begin
        repeat (15) @(negedge clk);
        chk(s_ready == 0, "R1 stall on full length queue", 32'(s_ready), 0);
        rd(AO, v, e); chk(v == LQ, "R2 occupancy full", v, LQ);
        rd(AL, v, e); rd(AD, v, e);
        chk(v == 32'h700, "R4 oldest of full queue", v, 32'h700);
      end
    join
    for (int p = 0; p < LQ; p++) begin rd(AL, v, e); rd(AD, v, e); end

    // data store full
    send_pkt(DEPTH, 32'h1000, 1);
    chk(s_ready == 0, "R1 stall on full data store", 32'(s_ready), 0);
    rd(AL, v, e); chk(v == DEPTH * 4, "R3 maximum length", v, DEPTH * 4);
    for (int k = 0; k < DEPTH; k++) rd(AD, v, e);
    chk(v == 32'h1000 + DEPTH - 1, "R4 last word of long packet", v, 32'h1000 + DEPTH - 1);

    // packet completion overlapping register reads
    fork
      send_pkt(4, 32'h2000, 1);
      for (int k = 0; k < 6; k++) begin
        rd(AO, v, e); rd(AL, v, e);
      end
    join
    rd(AO, v, e); rd(AL, ln, e);
    for (int k = 0; k < ln / 4; k++) rd(AD, v, e);

    // flush in the middle of an inbound packet
    fork
      send_pkt(6, 32'h3000, 0);
      begin repeat (2) @(negedge clk); wr(AF, 32'hA5, e); end
    join
    rd(AL, ln, e); chk(ln == 12, "R9 partial packet after flush", ln, 12);
    for (int k = 0; k < ln / 4; k++) rd(AD, v, e);
    rd(AD, v, e); chk(e[29], "R8 empty after drain", e, 32'h2000_0000);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule